// File: doc/BRIEF.md
# Load/Store Address and Byte-Lane Unit

This unit sits between an execution pipeline and a byte-addressed memory built from 32-bit words. For each request it forms the effective address from a base value and an offset. The offset is either a 12-bit immediate magnitude or a register value shifted left. It also decides whether the base register receives an updated value, and what that value is. Three indexing forms are supported. Plain pre-indexing uses the offset sum as the address and leaves the base alone. Pre-indexing with writeback uses the sum and also returns it for the base. Post-indexing uses the raw base as the address and returns the sum for the base.

Sub-word data is steered between its lane and bit 0 according to a static endianness input. Loads of bytes and halfwords are zero-extended. Stores repeat the data across the word and mark the target lanes with byte enables. Requests that are malformed or misaligned complete without touching memory. They report a fault flag alongside the one-cycle completion pulse.

Top module: `lsu_core`

## Requirements
- R1: The access address is base plus or minus the offset for pre-indexing (mode code 0) and pre-indexing with writeback (mode code 2), and the unmodified base for post-indexing (mode code 1). `mem_addr_o` carries this address with bits 1:0 cleared.
- R2: Writeback is signalled by `wb_en_o` together with `done_o`. It is raised only for mode codes 1 and 2, and only on requests without a fault. `wb_data_o` is base plus or minus the offset.
- R3: With `req_use_reg_i` low, the offset is the 12-bit immediate, zero-extended, so 0..4095 is added or subtracted. With it high, the offset is `req_reg_val_i` shifted left by `req_shift_i`. `req_sub_i` high selects subtraction.
- R4: Little-endian (`big_endian_i` low): the byte at address offset a is in bits 8a+7:8a. A halfword at offset h (0 or 2) is in bits 8h+15:8h.
- R5: Big-endian (`big_endian_i` high): the byte at offset a is in bits 8(3-a)+7:8(3-a). The halfword at offset 0 is in bits 31:16, and the halfword at offset 2 is in bits 15:0.
- R6: Size code 0 is a byte, size code 1 a halfword and size code 2 a word. Byte and halfword loads return the selected data zero-extended to 32 bits in `load_data_o`.
- R7: A store drives `mem_wdata_o` with the byte repeated four times, the halfword repeated twice, or the full word. `mem_be_o` bit k marks bits 8k+7:8k. Only the addressed lanes are changed in memory.
- R8: `illegal_o` is raised with `done_o`, with no memory access and no writeback, in these cases: size code 3, mode code 3, a register offset whose index is 15, or a register offset with a nonzero shift on a halfword access. A shifted register offset on a byte or word access is legal.
- R9: A halfword access with address bit 0 set, or a word access with address bits 1:0 nonzero, raises `misalign_o` with `done_o`. It makes no memory access and no writeback.
- R10: An accepted request holds `mem_valid_o`, address, enables and data until `mem_ready_i`. `done_o` is a one-cycle pulse in the cycle after the handshake. A faulting request pulses `done_o` in the cycle after acceptance.
- R11: During and right after reset, `req_ready_o` is high and `mem_valid_o` and `done_o` are low. `req_ready_o` is high only while no request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| big_endian_i | input | 1 | Static lane order select, high for big-endian |
| req_valid_i | input | 1 | Request present, taken when `req_ready_o` is high |
| req_ready_o | output | 1 | Unit idle and able to take a request |
| req_store_i | input | 1 | High for store, low for load |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_mode_i | input | 2 | 0 pre, 1 post, 2 pre with writeback, 3 reserved |
| req_sub_i | input | 1 | Subtract the offset instead of adding it |
| req_base_i | input | 32 | Base register value |
| req_imm_i | input | 12 | Immediate offset magnitude |
| req_use_reg_i | input | 1 | Use the register offset instead of the immediate |
| req_reg_idx_i | input | 4 | Index of the offset register |
| req_reg_val_i | input | 32 | Value of the offset register |
| req_shift_i | input | 5 | Left shift applied to the register offset |
| req_wdata_i | input | 32 | Store data, right-aligned |
| mem_valid_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_be_o | output | 4 | Byte enables for writes |
| mem_wdata_o | output | 32 | Lane-steered store data |
| mem_ready_i | input | 1 | Memory accepts; read data valid in the same cycle |
| mem_rdata_i | input | 32 | Memory read word |
| done_o | output | 1 | One-cycle completion pulse |
| load_data_o | output | 32 | Zero-extended load result, valid with `done_o` |
| wb_en_o | output | 1 | Base writeback valid |
| wb_data_o | output | 32 | Updated base value |
| misalign_o | output | 1 | Misalignment fault, valid with `done_o` |
| illegal_o | output | 1 | Illegal request, valid with `done_o` |

## Verification
The handshake checks assume a memory that delivers read data in the cycle where `mem_ready_i` is high. They also assume `mem_ready_i` is only driven while `mem_valid_o` is asserted. The bench memory model raises ready after a programmable wait, from zero to two cycles, and only during a pending request. `big_endian_i` is assumed constant during a transaction. The bench changes it only between sweeps, while the unit is idle. Request fields need to be valid only in the acceptance cycle, and the bench drives them there and lowers `req_valid_i` right after.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    IX_PRE    = 2'd0,
    IX_POST   = 2'd1,
    IX_PRE_WB = 2'd2,
    IX_RSVD   = 2'd3
  } index_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_RESP   = 2'd2
  } lsu_state_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned IMM_W  = 12,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned SH_W   = 5,
  parameter int unsigned PC_IDX = 15,
  parameter int unsigned LANES  = 4
) (
  input  size_e             size_i,
  input  index_e            mode_i,
  input  logic              sub_i,
  input  logic [AW-1:0]     base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_reg_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [AW-1:0]     reg_val_i,
  input  logic [SH_W-1:0]   shift_i,
  output logic [AW-1:0]     addr_o,
  output logic              wb_en_o,
  output logic [AW-1:0]     wb_data_o,
  output logic              illegal_o,
  output logic              misalign_o
);
  localparam int unsigned OFF_W = $clog2(LANES);
  localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

  logic [AW-1:0] offset;
  logic [AW-1:0] sum;
  logic          bad_reg;

  assign offset = use_reg_i ? (reg_val_i << shift_i) : {{(AW-IMM_W){1'b0}}, imm_i};
  assign sum    = sub_i ? (base_i - offset) : (base_i + offset);

  assign addr_o    = (mode_i == IX_POST) ? base_i : sum;
  assign wb_data_o = sum;
  assign wb_en_o   = (mode_i == IX_POST) || (mode_i == IX_PRE_WB);

  // pc as offset source, or scaled offset on a halfword
  assign bad_reg = use_reg_i &&
                   ((reg_idx_i == PC_SEL) || ((shift_i != '0) && (size_i == SZ_HALF)));

  assign illegal_o = (size_i == SZ_RSVD) || (mode_i == IX_RSVD) || bad_reg;

  always_comb begin
    misalign_o = 1'b0;
    if (!illegal_o) begin
      unique case (size_i)
        SZ_HALF: misalign_o = addr_o[0];
        SZ_WORD: misalign_o = (addr_o[OFF_W-1:0] != '0);
        default: misalign_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/lsu_lanes.sv
module lsu_lanes
  import lsu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                    big_endian_i,
  input  size_e                   size_i,
  input  logic [$clog2(DW/8)-1:0] lane_off_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [DW-1:0]           rdata_i,
  output logic [DW/8-1:0]         be_o,
  output logic [DW-1:0]           wdata_o,
  output logic [DW-1:0]           rdata_o
);
  localparam int unsigned LANES  = DW / 8;
  localparam int unsigned OFF_W  = $clog2(LANES);
  localparam int unsigned HALVES = LANES / 2;
  localparam int unsigned HS_W   = (OFF_W > 1) ? OFF_W - 1 : 1;

  logic [OFF_W-1:0] byte_lane;
  logic [HS_W-1:0]  half_slot;
  logic [HS_W-1:0]  half_raw;

  assign half_raw  = HS_W'(lane_off_i >> 1);
  assign byte_lane = big_endian_i ? (OFF_W'(LANES - 1) - lane_off_i) : lane_off_i;
  assign half_slot = big_endian_i ? (HS_W'(HALVES - 1) - half_raw) : half_raw;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: be_o = LANES'(1) << byte_lane;
      SZ_HALF: be_o = LANES'(3) << (2 * half_slot);
      default: be_o = '1;
    endcase
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: rdata_o = DW'(rdata_i[8*byte_lane +: 8]);
      SZ_HALF: rdata_o = DW'(rdata_i[16*half_slot +: 16]);
      default: rdata_o = rdata_i;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      unique case (size_i)
        SZ_BYTE: wdata_o[8*l +: 8] = wdata_i[7:0];
        SZ_HALF: wdata_o[8*l +: 8] = wdata_i[8*(l%2) +: 8];
        default: wdata_o[8*l +: 8] = wdata_i[8*l +: 8];
      endcase
    end
  end
endmodule

// File: rtl/lsu_core.sv
module lsu_core
  import lsu_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned IMM_W  = 12,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned SH_W   = 5,
  parameter int unsigned PC_IDX = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              big_endian_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_store_i,
  input  logic [1:0]        req_size_i,
  input  logic [1:0]        req_mode_i,
  input  logic              req_sub_i,
  input  logic [AW-1:0]     req_base_i,
  input  logic [IMM_W-1:0]  req_imm_i,
  input  logic              req_use_reg_i,
  input  logic [IDX_W-1:0]  req_reg_idx_i,
  input  logic [AW-1:0]     req_reg_val_i,
  input  logic [SH_W-1:0]   req_shift_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW/8-1:0]   mem_be_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              done_o,
  output logic [DW-1:0]     load_data_o,
  output logic              wb_en_o,
  output logic [AW-1:0]     wb_data_o,
  output logic              misalign_o,
  output logic              illegal_o
);
  localparam int unsigned LANES = DW / 8;
  localparam int unsigned OFF_W = $clog2(LANES);

  lsu_state_e    state_q;
  logic [AW-1:0] addr_q, wb_data_q;
  logic [DW-1:0] wdata_q, load_q;
  size_e         size_q;
  logic          store_q, wb_en_q, ill_q, mis_q;

  logic [AW-1:0] ag_addr, ag_wb_data;
  logic          ag_wb_en, ag_ill, ag_mis;
  logic [DW-1:0] ln_rdata, ln_wdata;
  logic [LANES-1:0] ln_be;

  lsu_agen #(
    .AW(AW), .IMM_W(IMM_W), .IDX_W(IDX_W), .SH_W(SH_W), .PC_IDX(PC_IDX), .LANES(LANES)
  ) u_agen (
    .size_i     (size_e'(req_size_i)),
    .mode_i     (index_e'(req_mode_i)),
    .sub_i      (req_sub_i),
    .base_i     (req_base_i),
    .imm_i      (req_imm_i),
    .use_reg_i  (req_use_reg_i),
    .reg_idx_i  (req_reg_idx_i),
    .reg_val_i  (req_reg_val_i),
    .shift_i    (req_shift_i),
    .addr_o     (ag_addr),
    .wb_en_o    (ag_wb_en),
    .wb_data_o  (ag_wb_data),
    .illegal_o  (ag_ill),
    .misalign_o (ag_mis)
  );

  lsu_lanes #(.DW(DW)) u_lanes (
    .big_endian_i (big_endian_i),
    .size_i       (size_q),
    .lane_off_i   (addr_q[OFF_W-1:0]),
    .wdata_i      (wdata_q),
    .rdata_i      (mem_rdata_i),
    .be_o         (ln_be),
    .wdata_o      (ln_wdata),
    .rdata_o      (ln_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      wb_data_q <= '0;
      wdata_q   <= '0;
      load_q    <= '0;
      size_q    <= SZ_WORD;
      store_q   <= 1'b0;
      wb_en_q   <= 1'b0;
      ill_q     <= 1'b0;
      mis_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            addr_q    <= ag_addr;
            wb_data_q <= ag_wb_data;
            wdata_q   <= req_wdata_i;
            size_q    <= size_e'(req_size_i);
            store_q   <= req_store_i;
            wb_en_q   <= ag_wb_en;
            ill_q     <= ag_ill;
            mis_q     <= ag_mis;
            load_q    <= '0;
            state_q   <= (ag_ill || ag_mis) ? ST_RESP : ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          if (mem_ready_i) begin
            if (!store_q) load_q <= ln_rdata;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_valid_o = (state_q == ST_ACCESS);
  assign mem_we_o    = mem_valid_o && store_q;
  assign mem_addr_o  = {addr_q[AW-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_be_o    = ln_be;
  assign mem_wdata_o = ln_wdata;

  assign done_o      = (state_q == ST_RESP);
  assign load_data_o = load_q;
  assign wb_data_o   = wb_data_q;
  assign illegal_o   = done_o && ill_q;
  assign misalign_o  = done_o && mis_q;
  assign wb_en_o     = done_o && wb_en_q && !ill_q && !mis_q;

  a_r10_hold_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) &&
                                     $stable(mem_be_o) && $stable(mem_wdata_o));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_fault_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (misalign_o || illegal_o) |-> !$past(mem_valid_o));

  a_r2_wb_only_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> done_o && !illegal_o && !misalign_o);

  a_r7_store_has_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_be_o != '0);

  a_r11_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_valid_o && !done_o);
endmodule

// File: tb/tb_lsu_core.sv
module tb_lsu_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        big_endian;
  logic        req_valid, req_ready, req_store, req_sub, req_use_reg;
  logic [1:0]  req_size, req_mode;
  logic [31:0] req_base, req_reg_val, req_wdata;
  logic [11:0] req_imm;
  logic [3:0]  req_reg_idx;
  logic [4:0]  req_shift;
  logic        mem_valid, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        done, wb_en, misalign, illegal;
  logic [31:0] load_data, wb_data;

  lsu_core dut (
    .clk_i(clk), .rst_ni(rst_n), .big_endian_i(big_endian),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_store_i(req_store),
    .req_size_i(req_size), .req_mode_i(req_mode), .req_sub_i(req_sub),
    .req_base_i(req_base), .req_imm_i(req_imm), .req_use_reg_i(req_use_reg),
    .req_reg_idx_i(req_reg_idx), .req_reg_val_i(req_reg_val), .req_shift_i(req_shift),
    .req_wdata_i(req_wdata),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata),
    .done_o(done), .load_data_o(load_data), .wb_en_o(wb_en), .wb_data_o(wb_data),
    .misalign_o(misalign), .illegal_o(illegal)
  );

  // memory model
  logic [31:0] mem [16];
  int          wait_cnt, acc_cnt, lat;
  logic [31:0] last_addr, last_wd;
  logic [3:0]  last_be;

  function automatic logic [31:0] init_word(int i);
    return 32'hA5C3_0F11 ^ (32'(i) * 32'h0103_0507);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
      wait_cnt <= 0;
      acc_cnt  <= 0;
    end else begin
      if (mem_valid && !mem_ready) wait_cnt <= wait_cnt + 1;
      else wait_cnt <= 0;
      if (mem_valid && mem_ready) begin
        acc_cnt   <= acc_cnt + 1;
        last_addr <= mem_addr;
        last_be   <= mem_be;
        last_wd   <= mem_wdata;
        if (mem_we)
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
    end
  end
  assign mem_ready = mem_valid && (wait_cnt >= lat);
  assign mem_rdata = mem[mem_addr[5:2]];

  int checks = 0, errors = 0;
  logic [31:0] shadow [16];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // captured results
  int          r_lat, r_acc;
  logic [31:0] r_load, r_wb;
  logic        r_wb_en, r_mis, r_ill, r_after;

  task automatic issue(input bit st, input logic [1:0] sz, input logic [1:0] md, input bit sb,
                       input logic [31:0] base, input logic [11:0] imm, input bit ur,
                       input logic [3:0] ridx, input logic [31:0] rval, input logic [4:0] sh,
                       input logic [31:0] wd);
    int a0, k;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_store = st; req_size = sz; req_mode = md; req_sub = sb; req_base = base;
    req_imm = imm; req_use_reg = ur; req_reg_idx = ridx; req_reg_val = rval;
    req_shift = sh; req_wdata = wd; req_valid = 1'b1;
    a0 = acc_cnt;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    while (!done && k < 20) begin @(negedge clk); k++; end
    r_lat = k; r_load = load_data; r_wb = wb_data; r_wb_en = wb_en;
    r_mis = misalign; r_ill = illegal; r_acc = acc_cnt - a0;
    @(negedge clk);
    r_after = done;
  endtask

  task automatic run_all();
    int n = 0;
    // R11 reset state
    chk(req_ready === 1'b1, "R11", 32'(req_ready), 1);
    chk(mem_valid === 1'b0, "R11", 32'(mem_valid), 0);
    chk(done === 1'b0, "R11", 32'(done), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && mem_valid === 1'b0 && done === 1'b0, "R11",
        {req_ready, mem_valid, done}, 32'b100);

    // sweep: endianness x size x offset x dir x mode x add/sub
    for (int be = 0; be < 2; be++) begin
      big_endian = be[0];
      for (int sz = 0; sz < 3; sz++)
        for (int a = 0; a < 4; a++)
          for (int st = 0; st < 2; st++)
            for (int md = 0; md < 3; md++)
              for (int sb = 0; sb < 2; sb++) begin
                logic [31:0] t, base, exp_wb, mask, exp_wd, exp_load, wd;
                logic [11:0] off;
                int sh, idx;
                bit mis;
                string lt;
                lt = be ? "R5" : "R4";
                n++;
                lat = n % 3;
                t = 32'h20 + 32'(4 * (n % 4)) + 32'(a);
                off = 12'((n * 37) % 400 + 1);
                wd = $urandom;
                if (md == 1) base = t;
                else base = sb ? t + 32'(off) : t - 32'(off);
                exp_wb = sb ? base - 32'(off) : base + 32'(off);
                mis = (sz == 1 && a[0]) || (sz == 2 && a != 0);
                idx = int'(t[5:2]);
                case (sz)
                  0: begin sh = be ? (3 - a) * 8 : a * 8; mask = 32'hFF << sh;
                       exp_wd = {4{wd[7:0]}}; end
                  1: begin sh = be ? (2 - a) * 8 : a * 8; mask = 32'hFFFF << sh;
                       exp_wd = {2{wd[15:0]}}; end
                  default: begin sh = 0; mask = 32'hFFFF_FFFF; exp_wd = wd; end
                endcase
                exp_load = (shadow[idx] & mask) >> sh;
                issue(st[0], 2'(sz), 2'(md), sb[0], base, off, 1'b0, 4'd0, 32'd0, 5'd0, wd);
                chk(r_mis == mis, "R9", 32'(r_mis), 32'(mis));
                chk(r_ill == 1'b0, "R8", 32'(r_ill), 0);
                chk(r_after == 1'b0, "R10", 32'(r_after), 0);
                if (mis) begin
                  chk(r_acc == 0, "R9", 32'(r_acc), 0);
                  chk(r_lat == 0, "R10", 32'(r_lat), 0);
                  chk(r_wb_en == 1'b0, "R9", 32'(r_wb_en), 0);
                  chk(mem[idx] == shadow[idx], "R9", mem[idx], shadow[idx]);
                end else begin
                  chk(r_acc == 1, "R10", 32'(r_acc), 1);
                  chk(r_lat == 1 + lat, "R10", 32'(r_lat), 32'(1 + lat));
                  chk(last_addr == {t[31:2], 2'b00}, "R1", last_addr, {t[31:2], 2'b00});
                  chk(r_wb_en == (md != 0), "R2", 32'(r_wb_en), 32'(md != 0));
                  if (md != 0) chk(r_wb == exp_wb, "R2", r_wb, exp_wb);
                  if (st) begin
                    shadow[idx] = (shadow[idx] & ~mask) | ((exp_wd) & mask);
                    chk(last_be == {mask[24], mask[16], mask[8], mask[0]}, lt,
                        32'(last_be), 32'({mask[24], mask[16], mask[8], mask[0]}));
                    chk(last_wd == exp_wd, "R7", last_wd, exp_wd);
                    chk(mem[idx] == shadow[idx], "R7", mem[idx], shadow[idx]);
                  end else begin
                    chk(r_load == exp_load, sz == 2 ? "R6" : lt, r_load, exp_load);
                    chk(r_load == (r_load & (sz == 0 ? 32'hFF : sz == 1 ? 32'hFFFF : 32'hFFFF_FFFF)),
                        "R6", r_load, exp_load);
                  end
                end
              end
    end

    big_endian = 1'b0;
    lat = 1;
    // R3 register offset, shifted, word
    issue(1'b0, 2'd2, 2'd0, 1'b0, 32'h20, 12'd0, 1'b1, 4'd3, 32'd2, 5'd2, 32'd0);
    chk(last_addr == 32'h28, "R3", last_addr, 32'h28);
    chk(r_load == shadow[10], "R3", r_load, shadow[10]);
    // R3 register offset subtract, post, byte
    issue(1'b0, 2'd0, 2'd1, 1'b1, 32'h31, 12'd0, 1'b1, 4'd7, 32'd5, 5'd0, 32'd0);
    chk(last_addr == 32'h30, "R3", last_addr, 32'h30);
    chk(r_wb_en && r_wb == 32'h2C, "R3", r_wb, 32'h2C);
    chk(r_load == ((shadow[12] >> 8) & 32'hFF), "R3", r_load, (shadow[12] >> 8) & 32'hFF);
    // R3 max immediate subtract with writeback
    issue(1'b0, 2'd0, 2'd2, 1'b1, 32'h1021, 12'hFFF, 1'b0, 4'd0, 32'd0, 5'd0, 32'd0);
    chk(r_wb == 32'h22 && last_addr == 32'h20, "R3", r_wb, 32'h22);
    chk(r_load == ((shadow[8] >> 16) & 32'hFF), "R3", r_load, (shadow[8] >> 16) & 32'hFF);
    // R8 pc as offset register
    issue(1'b1, 2'd2, 2'd2, 1'b0, 32'h20, 12'd0, 1'b1, 4'd15, 32'd4, 5'd0, 32'hDEAD_BEEF);
    chk(r_ill && r_acc == 0 && !r_wb_en && r_lat == 0, "R8", {r_ill, 31'(r_acc)}, 32'h8000_0000);
    chk(mem[9] == shadow[9] && mem[8] == shadow[8], "R8", mem[9], shadow[9]);
    // R8 scaled register on halfword
    issue(1'b0, 2'd1, 2'd0, 1'b0, 32'h20, 12'd0, 1'b1, 4'd2, 32'd1, 5'd1, 32'd0);
    chk(r_ill && r_acc == 0, "R8", 32'(r_ill), 1);
    // R8 unscaled halfword register offset is legal
    issue(1'b0, 2'd1, 2'd0, 1'b0, 32'h20, 12'd0, 1'b1, 4'd2, 32'd2, 5'd0, 32'd0);
    chk(!r_ill && r_acc == 1 && r_load == (shadow[8] >> 16), "R8", r_load, shadow[8] >> 16);
    // R8 scaled register on byte is legal
    issue(1'b0, 2'd0, 2'd0, 1'b0, 32'h20, 12'd0, 1'b1, 4'd2, 32'd1, 5'd2, 32'd0);
    chk(!r_ill && r_acc == 1 && r_load == ((shadow[9]) & 32'hFF), "R8", r_load, shadow[9] & 32'hFF);
    // R8 reserved size and mode codes, stores must not land
    issue(1'b1, 2'd3, 2'd0, 1'b0, 32'h24, 12'd0, 1'b0, 4'd0, 32'd0, 5'd0, 32'h1234_5678);
    chk(r_ill && r_acc == 0 && mem[9] == shadow[9], "R8", mem[9], shadow[9]);
    issue(1'b1, 2'd2, 2'd3, 1'b0, 32'h24, 12'd0, 1'b0, 4'd0, 32'd0, 5'd0, 32'h1234_5678);
    chk(r_ill && r_acc == 0 && !r_wb_en && mem[9] == shadow[9], "R8", mem[9], shadow[9]);
    chk(!r_mis, "R8", 32'(r_mis), 0);
    // R2 plain pre-index never writes back
    issue(1'b0, 2'd2, 2'd0, 1'b0, 32'h20, 12'd4, 1'b0, 4'd0, 32'd0, 5'd0, 32'd0);
    chk(!r_wb_en && r_load == shadow[9], "R2", r_load, shadow[9]);
  endtask

  initial begin
    bit timeout = 0;
    big_endian = 0; req_valid = 0; req_store = 0; req_size = 0; req_mode = 0;
    req_sub = 0; req_base = 0; req_imm = 0; req_use_reg = 0; req_reg_idx = 0;
    req_reg_val = 0; req_shift = 0; req_wdata = 0; lat = 0;
    for (int i = 0; i < 16; i++) shadow[i] = init_word(i);
    repeat (3) @(negedge clk);
    fork
      run_all();
      begin repeat (100000) @(posedge clk); timeout = 1; end
    join_any
    disable fork;
    if (timeout) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule